// File: doc/BRIEF.md
# GPIO Bank Interrupt Controller

This block serves a bank of 32 general-purpose I/O lines through a small word-addressed register bus. Software picks the direction of each line and drives an output latch. Each of these is changed through a pair of registers: one sets bits and the other clears them. A write therefore touches only the lines whose bits are written as 1, and no read-modify-write sequence is needed. Every pad input passes through a two-flop synchroniser before software or the interrupt logic sees it.

The lowest `NUM_IRQ` lines (eight by default) can raise an interrupt. Each of them takes a trigger type built from three bits: a rise enable, a fall enable and a level select. In edge mode these bits choose rising, falling or both edges, and a detected edge sets a sticky status bit that stays until software clears it. In level mode the same enables choose a high-active or a low-active trigger, and the status bit follows the qualified input level. An optional per-line debounce filter accepts a new input value only after it has held for a fixed number of sampled cycles. All visible status bits are ORed into a single interrupt output.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset all lines are inputs (`pad_oe` = 0), `pad_out` = 0, the interrupt control word (read at 0x18) is 0, the status word (read at 0x24) is 0 and `irq_o` is low.
- R2: Writing 1s to 0x04 turns those lines into outputs (`pad_oe` bit = 1) and writing 1s to 0x08 turns them into inputs; bits written as 0 leave their lines unchanged; 0x00 reads the direction word.
- R3: Writing 1s to 0x10 sets output latch bits and writing 1s to 0x14 clears them; bits written as 0 have no effect; `pad_out` always shows the latch, whatever the direction; 0x10 reads the latch.
- R4: 0x0C reads the synchronised pad inputs: a pad change made before clock edge k is visible on the bus after edge k+1 and not after edge k.
- R5: The control word has rise enables in bits 7:0, fall enables in bits 15:8, debounce enables in bits 23:16 and level selects in bits 31:24 (bit n of each field serves line n); writing 1s to 0x18 sets bits, writing 1s to 0x1C clears bits, and both addresses read the word back.
- R6: In edge mode (level select 0) the rise enable captures rising edges, the fall enable captures falling edges, and both capture either edge; with debounce off, a pad change before edge k sets the status bit after edge k+3 and not earlier; an edge of a direction that is not enabled sets nothing.
- R7: Writing 1s to 0x20 clears those sticky status bits, bits written as 0 keep theirs, and 0x20 always reads 0.
- R8: In level mode the status bit is 1 while the input is high (rise enable) or low (fall enable), follows the input back to 0, and is unaffected by writes to 0x20.
- R9: A line with both rise and fall enable clear reads 0 in status and adds nothing to `irq_o`, yet keeps its sticky bit for when an enable returns; lines at or above `NUM_IRQ` never interrupt and status bits 31:`NUM_IRQ` read 0.
- R10: `irq_o` is the OR of the visible status bits 7:0.
- R11: With a line's debounce bit set, a new input value is accepted only after it has been sampled on 4 consecutive cycles (`DEB_CYCLES`); a 3-cycle pulse is ignored and a 4-cycle pulse is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 6 | Byte address; bits 1:0 must be 0 for an access to hit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Output latch to the pads |
| pad_oe | output | 32 | Per-line output enable (1 = output) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: eight interrupt-capable lines and a four-sample debounce window. With these values every trigger encoding on every interrupt line can be reached. The exact cycle of status capture can be checked. A three-cycle glitch can be set against a four-cycle pulse right at the debounce threshold. The upper lines can be toggled to show that they never reach the status word or the interrupt output.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Bus geometry
    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 6;
    localparam int FIELD_W = 8;
    localparam int WORD_W  = ADDR_W - 2;

    // Word indices (byte address / 4)
    localparam logic [WORD_W-1:0] W_DIR      = 4'd0;
    localparam logic [WORD_W-1:0] W_DIR_OUT  = 4'd1;
    localparam logic [WORD_W-1:0] W_DIR_IN   = 4'd2;
    localparam logic [WORD_W-1:0] W_LEVEL    = 4'd3;
    localparam logic [WORD_W-1:0] W_OUT_SET  = 4'd4;
    localparam logic [WORD_W-1:0] W_OUT_CLR  = 4'd5;
    localparam logic [WORD_W-1:0] W_CFG_SET  = 4'd6;
    localparam logic [WORD_W-1:0] W_CFG_CLR  = 4'd7;
    localparam logic [WORD_W-1:0] W_STAT_CLR = 4'd8;
    localparam logic [WORD_W-1:0] W_STATUS   = 4'd9;

    // Field offsets inside the control word
    localparam int F_RISE = 0;
    localparam int F_FALL = FIELD_W;
    localparam int F_DEB  = 2 * FIELD_W;
    localparam int F_LVL  = 3 * FIELD_W;

    typedef struct packed {
        logic [BUS_W-1:0] dir;
        logic [BUS_W-1:0] outl;
        logic [BUS_W-1:0] cfg;
    } bank_state_t;

endpackage

// File: rtl/gpio_line_sync.sv
module gpio_line_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d.s1 = async_in;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sync_out = r_q.s2;

endmodule

// File: rtl/gpio_deb_filter.sv
module gpio_deb_filter #(
    parameter int DEB_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic deb_en,
    input  logic raw_in,
    output logic clean_out
);

    localparam int            CW   = $clog2(DEB_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    typedef struct packed {
        logic          val;
        logic [CW-1:0] cnt;
    } deb_t;

    deb_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (!deb_en) begin
            // Filter bypassed: follow the sample directly
            f_d.val = raw_in;
            f_d.cnt = '0;
        end else if (raw_in == f_q.val) begin
            f_d.cnt = '0;
        end else if (f_q.cnt == LAST) begin
            // Differing value seen on DEB_CYCLES consecutive samples
            f_d.val = raw_in;
            f_d.cnt = '0;
        end else begin
            f_d.cnt = f_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign clean_out = f_q.val;

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int NUM_IRQ    = 8,
    parameter int DEB_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] line_in,
    input  logic [NUM_IRQ-1:0] rise_en,
    input  logic [NUM_IRQ-1:0] fall_en,
    input  logic [NUM_IRQ-1:0] deb_en,
    input  logic [NUM_IRQ-1:0] lvl_sel,
    input  logic [NUM_IRQ-1:0] clr_mask,
    output logic [NUM_IRQ-1:0] status_o
);

    logic [NUM_IRQ-1:0] clean;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        gpio_deb_filter #(
            .DEB_CYCLES(DEB_CYCLES)
        ) u_deb (
            .clk      (clk),
            .rst_n    (rst_n),
            .deb_en   (deb_en[i]),
            .raw_in   (line_in[i]),
            .clean_out(clean[i])
        );
    end

    typedef struct packed {
        logic [NUM_IRQ-1:0] prev;
        logic [NUM_IRQ-1:0] sticky;
    } irq_t;

    irq_t i_d, i_q;
    logic [NUM_IRQ-1:0] rise_ev, fall_ev, edge_ev, lvl_hit;

    always_comb begin
        rise_ev = clean & ~i_q.prev;
        fall_ev = ~clean & i_q.prev;
        edge_ev = (rise_en & rise_ev) | (fall_en & fall_ev);
        lvl_hit = (rise_en & clean) | (fall_en & ~clean);

        i_d.prev = clean;
        // Level lines track the qualified level; edge lines hold until
        // cleared, and a new event in the clear cycle wins.
        i_d.sticky = (lvl_sel & lvl_hit)
                   | (~lvl_sel & ((i_q.sticky & ~clr_mask) | edge_ev));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) i_q <= '0;
        else        i_q <= i_d;
    end

    // A line with no enable is masked but keeps its sticky bit
    assign status_o = i_q.sticky & (rise_en | fall_en);

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_IRQ    = 8,
    parameter int DEB_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [BUS_W-1:0]  pad_in,
    output logic [BUS_W-1:0]  pad_out,
    output logic [BUS_W-1:0]  pad_oe,
    output logic              irq_o
);

    logic              aligned;
    logic              wr_hit;
    logic [WORD_W-1:0] word;

    assign word    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_hit  = bus_we & aligned;

    bank_state_t        st_d, st_q;
    logic [BUS_W-1:0]   line_sync;
    logic [NUM_IRQ-1:0] clr_mask;
    logic [NUM_IRQ-1:0] stat_vis;

    // Next-state: set/clear register pairs
    always_comb begin
        st_d     = st_q;
        clr_mask = '0;
        if (wr_hit) begin
            case (word)
                W_DIR_OUT:  st_d.dir  = st_q.dir  |  bus_wdata;
                W_DIR_IN:   st_d.dir  = st_q.dir  & ~bus_wdata;
                W_OUT_SET:  st_d.outl = st_q.outl |  bus_wdata;
                W_OUT_CLR:  st_d.outl = st_q.outl & ~bus_wdata;
                W_CFG_SET:  st_d.cfg  = st_q.cfg  |  bus_wdata;
                W_CFG_CLR:  st_d.cfg  = st_q.cfg  & ~bus_wdata;
                W_STAT_CLR: clr_mask  = bus_wdata[NUM_IRQ-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    gpio_line_sync #(
        .WIDTH(BUS_W)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pad_in),
        .sync_out(line_sync)
    );

    gpio_irq_unit #(
        .NUM_IRQ   (NUM_IRQ),
        .DEB_CYCLES(DEB_CYCLES)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_sync[NUM_IRQ-1:0]),
        .rise_en (st_q.cfg[F_RISE +: NUM_IRQ]),
        .fall_en (st_q.cfg[F_FALL +: NUM_IRQ]),
        .deb_en  (st_q.cfg[F_DEB  +: NUM_IRQ]),
        .lvl_sel (st_q.cfg[F_LVL  +: NUM_IRQ]),
        .clr_mask(clr_mask),
        .status_o(stat_vis)
    );

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (word)
                W_DIR, W_DIR_OUT, W_DIR_IN: bus_rdata = st_q.dir;
                W_LEVEL:                    bus_rdata = line_sync;
                W_OUT_SET, W_OUT_CLR:       bus_rdata = st_q.outl;
                W_CFG_SET, W_CFG_CLR:       bus_rdata = st_q.cfg;
                W_STATUS:                   bus_rdata[NUM_IRQ-1:0] = stat_vis;
                default: ;
            endcase
        end
    end

    assign pad_out = st_q.outl;
    assign pad_oe  = st_q.dir;
    assign irq_o   = |stat_vis;

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [BUS_W-1:0]  pad_oe,
    input logic [BUS_W-1:0]  pad_out,
    input logic              irq_o
);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_idle_r1: assert (pad_oe == '0 && pad_out == '0 && !irq_o)
                else $error("reset state not idle");
        end
    end

    p_oe_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pad_oe))
        else $error("direction changed without a write");

    p_dir_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 6'h04) |=> ((pad_oe & $past(bus_wdata)) == $past(bus_wdata)))
        else $error("set-output write missed a line");

    p_dir_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 6'h08) |=> ((pad_oe & $past(bus_wdata)) == '0))
        else $error("set-input write missed a line");

    p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pad_out))
        else $error("output latch changed without a write");

    p_out_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 6'h10) |=> ((pad_out & $past(bus_wdata)) == $past(bus_wdata)))
        else $error("output set write missed a bit");

    p_stat_clr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 6'h20) |-> (bus_rdata == '0))
        else $error("status-clear address read nonzero");

    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 6'h24) |-> (bus_rdata[BUS_W-1:NUM_IRQ] == '0))
        else $error("status bits above interrupt lines set");

    p_irq_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 6'h24) |-> (irq_o == (|bus_rdata)))
        else $error("interrupt output disagrees with status");

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .irq_o    (irq_o)
);

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_bank i_gpio_irq_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .irq_o    (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // All tasks below start and end at a falling clock edge
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic quiesce();
        wr(6'h1C, 32'hFFFF_FFFF);
        wr(6'h20, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 irq_o", {31'h0, irq_o}, 32'h0);
        peek(6'h18, v); check("R1 control word", v, 32'h0);
        peek(6'h24, v); check("R1 status", v, 32'h0);
    endtask

    task automatic t_direction();
        logic [31:0] v;
        wr(6'h04, 32'h0000_F00F); check("R2 set output", pad_oe, 32'h0000_F00F);
        wr(6'h04, 32'h0010_0000); check("R2 set output keeps others", pad_oe, 32'h0010_F00F);
        wr(6'h08, 32'h0000_000F); check("R2 set input", pad_oe, 32'h0010_F000);
        wr(6'h08, 32'h0);         check("R2 zero write no effect", pad_oe, 32'h0010_F000);
        peek(6'h00, v);           check("R2 direction readback", v, 32'h0010_F000);
    endtask

    task automatic t_output();
        logic [31:0] v;
        wr(6'h10, 32'hA5A5_0000); check("R3 output set", pad_out, 32'hA5A5_0000);
        wr(6'h14, 32'h0505_0000); check("R3 output clear", pad_out, 32'hA0A0_0000);
        wr(6'h10, 32'h0);         check("R3 zero write no effect", pad_out, 32'hA0A0_0000);
        peek(6'h10, v);           check("R3 latch readback", v, 32'hA0A0_0000);
        wr(6'h08, 32'hFFFF_FFFF); check("R3 latch kept on inputs", pad_out, 32'hA0A0_0000);
    endtask

    task automatic t_input();
        logic [31:0] v;
        pad_in = 32'hBEEF_0000;
        step(1); peek(6'h0C, v); check("R4 not yet after one edge", v, 32'h0);
        step(1); peek(6'h0C, v); check("R4 visible after two edges", v, 32'hBEEF_0000);
        pad_in = 32'h0;
        step(3);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        wr(6'h18, 32'h8142_2418); peek(6'h18, v); check("R5 control set", v, 32'h8142_2418);
        wr(6'h1C, 32'h8100_0010); peek(6'h1C, v); check("R5 control clear", v, 32'h0042_2408);
        quiesce();                peek(6'h18, v); check("R5 control all clear", v, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        // rising only on line 2 (bit 2)
        wr(6'h18, 32'h0000_0004);
        pad_in[2] = 1'b1;
        step(3); peek(6'h24, v); check("R6 rise not before edge k+3", v, 32'h0);
        step(1); peek(6'h24, v); check("R6 rise captured at edge k+3", v, 32'h4);
        check("R10 irq high with status", {31'h0, irq_o}, 32'h1);
        wr(6'h20, 32'h4);
        pad_in[2] = 1'b0;
        step(6); peek(6'h24, v); check("R6 fall ignored by rise enable", v, 32'h0);
        check("R10 irq low with no status", {31'h0, irq_o}, 32'h0);
        quiesce();
        // falling only on line 3 (bit 11)
        wr(6'h18, 32'h0000_0800);
        pad_in[3] = 1'b1;
        step(6); peek(6'h24, v); check("R6 rise ignored by fall enable", v, 32'h0);
        pad_in[3] = 1'b0;
        step(6); peek(6'h24, v); check("R6 fall captured", v, 32'h8);
        quiesce();
        // both edges on line 4 (bits 4 and 12)
        wr(6'h18, 32'h0000_1010);
        pad_in[4] = 1'b1;
        step(6); peek(6'h24, v); check("R6 both: rise captured", v, 32'h10);
        wr(6'h20, 32'h10);
        pad_in[4] = 1'b0;
        step(6); peek(6'h24, v); check("R6 both: fall captured", v, 32'h10);
        quiesce();
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(6'h18, 32'h0000_0014);
        pad_in[2] = 1'b1; pad_in[4] = 1'b1;
        step(6); peek(6'h24, v); check("R7 two sticky bits", v, 32'h14);
        wr(6'h20, 32'h0000_0004);
        peek(6'h24, v); check("R7 selective clear", v, 32'h10);
        peek(6'h20, v); check("R7 clear register reads zero", v, 32'h0);
        pad_in[2] = 1'b0; pad_in[4] = 1'b0;
        step(6);
        quiesce();
    endtask

    task automatic t_level();
        logic [31:0] v;
        // line 0 high-active: rise bit 0, level bit 24
        wr(6'h18, 32'h0100_0001);
        step(2); peek(6'h24, v); check("R8 high level idle", v, 32'h0);
        pad_in[0] = 1'b1;
        step(5); peek(6'h24, v); check("R8 high level asserted", v, 32'h1);
        wr(6'h20, 32'h1);
        step(1); peek(6'h24, v); check("R8 clear ignored in level mode", v, 32'h1);
        pad_in[0] = 1'b0;
        step(5); peek(6'h24, v); check("R8 high level released", v, 32'h0);
        quiesce();
        // line 1 low-active: fall bit 9, level bit 25
        wr(6'h18, 32'h0200_0200);
        step(1); peek(6'h24, v); check("R8 low level asserted", v, 32'h2);
        pad_in[1] = 1'b1;
        step(5); peek(6'h24, v); check("R8 low level released", v, 32'h0);
        pad_in[1] = 1'b0;
        step(3);
        quiesce();
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(6'h18, 32'h0000_0004);
        pad_in[2] = 1'b1;
        step(6); peek(6'h24, v); check("R9 sticky before mask", v, 32'h4);
        wr(6'h1C, 32'h0000_0004);
        peek(6'h24, v); check("R9 masked line reads zero", v, 32'h0);
        check("R9 masked line no irq", {31'h0, irq_o}, 32'h0);
        wr(6'h18, 32'h0000_0004);
        peek(6'h24, v); check("R9 sticky kept through mask", v, 32'h4);
        quiesce();
        pad_in[2] = 1'b0;
        step(6);
        quiesce();
        // upper lines cannot interrupt
        wr(6'h18, 32'h0000_FFFF);
        pad_in[31:8] = 24'hFFFFFF;
        step(6);
        pad_in[31:8] = 24'h0;
        step(6); peek(6'h24, v); check("R9 upper lines never set status", v, 32'h0);
        check("R9 upper lines no irq", {31'h0, irq_o}, 32'h0);
        quiesce();
    endtask

    task automatic t_debounce();
        logic [31:0] v;
        // line 5 rising edge with debounce (bits 5 and 21)
        wr(6'h18, 32'h0020_0020);
        pad_in[5] = 1'b1; step(3); pad_in[5] = 1'b0;
        step(12); peek(6'h24, v); check("R11 3-cycle glitch rejected", v, 32'h0);
        pad_in[5] = 1'b1; step(4); pad_in[5] = 1'b0;
        step(12); peek(6'h24, v); check("R11 4-cycle pulse accepted", v, 32'h20);
        wr(6'h1C, 32'h0020_0000);
        wr(6'h20, 32'h20);
        step(2);
        pad_in[5] = 1'b1; step(1); pad_in[5] = 1'b0;
        step(8); peek(6'h24, v); check("R11 short pulse passes without debounce", v, 32'h20);
        quiesce();
    endtask

    initial begin
        rst_n = 1'b1;
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_output();
        t_input();
        t_ctrl();
        t_edge();
        t_clear();
        t_level();
        t_mask();
        t_debounce();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule